// File: doc/BRIEF.md
# Serial Audio Bit-Clock and Frame-Sync Generator

This block makes the timing for a serial audio port that is master of its bit clock and frame sync. A source clock is divided down to a bit clock. The source is either the block's own functional clock or an external clock pin, which is synchronised and edge-detected. A frame counter then counts bit clocks to form a frame sync whose period and pulse width are set as two independent bit-clock counts. The output bit clock and the frame sync each have their own polarity bit. A one-cycle strobe marks the first bit clock of every frame.

Two enables control the block. The divider enable starts and stops the bit clock. The frame enable releases the frame counter, and the frame counter runs only while the divider also runs. A mode bit selects either a repeating frame sync, with one pulse in every period, or a single frame after the enables are asserted. For symmetric stereo, the period is set to twice the sample width minus one and the width to the sample width minus one. This gives a frame clock with 50% duty.

Top module: `sclk_fsync_gen`

## Requirements
- R1: With the internal source selected, the bit-clock phase toggles once every `div_val_i + 1` functional clock cycles; a divide value of 0 toggles on every cycle.
- R2: With `src_ext_i` = 1, the divider counts rising edges of `ext_clk_i` instead of functional clock cycles, so the bit-clock phase toggles once every `div_val_i + 1` external rising edges.
- R3: In periodic mode (`fs_per_mode_i` = 1), each frame lasts `per_val_i + 1` bit clocks, for any period value from 0 to 4095. The frame sync is active for the first `min(wid_val_i, per_val_i) + 1` bit clocks of the frame, starting on the frame's first bit clock.
- R4: No frame sync and no frame strobe are produced unless both `div_en_i` and `fs_en_i` are 1. The bit clock runs with `div_en_i` alone.
- R5: When `div_en_i` is cleared, the bit clock returns to its inactive level on the next clock edge. Clearing either enable returns the frame sync to inactive and resets the frame counter, so the first frame after re-enabling is complete.
- R6: `clk_pol_i` = 1 inverts the bit clock, so the idle level is high. `fs_pol_i` = 1 makes the frame sync active low.
- R7: In single mode (`fs_per_mode_i` = 0), exactly one frame is produced after the enables are asserted. The frame sync is active for `min(wid_val_i, per_val_i) + 1` bit clocks and then stays inactive until an enable is cleared.
- R8: `fstart_o` is high for exactly one clock cycle per frame. That cycle is the one in which the bit clock moves from its inactive to its active level at the start of the frame, and the frame sync is active in it.
- R9: After synchronous reset, the bit clock is at its inactive level, the frame sync is inactive and `fstart_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_i | input | 1 | External source clock pin, asynchronous |
| div_en_i | input | 1 | Divider enable; low holds the bit clock idle |
| fs_en_i | input | 1 | Frame-sync generation enable |
| src_ext_i | input | 1 | 1 selects the external pin as divider source |
| fs_per_mode_i | input | 1 | 1 gives a repeating frame sync, 0 a single frame |
| clk_pol_i | input | 1 | 1 inverts the bit clock (idle high) |
| fs_pol_i | input | 1 | 1 makes the frame sync active low |
| div_val_i | input | 8 | Divide value; phase toggles every value+1 source events |
| per_val_i | input | 12 | Frame period in bit clocks minus one |
| wid_val_i | input | 12 | Frame-sync width in bit clocks minus one |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync |
| fstart_o | output | 1 | One-cycle strobe on the first bit clock of a frame |

## Verification
The divider is measured with divide values 0 and 3 on the internal source, and with value 1 on a slow external pin. These cases separate an off-by-one in the terminal count from a wrong source selection. Frame shapes of period 8 with width 1, symmetric 32/16, odd 33/16 and maximal 4096/1 go through a scoreboard that counts bit clocks and active frame-sync bits per frame. These shapes show whether period and width are decoded independently and whether the full 12-bit range reaches the counter. Enable-only-divider, disable-and-restart, inverted polarities and single mode each show whether the frame sync is correctly gated or resumed. The strobe is checked on every bit clock for timing and coincidence with the sync.

// File: rtl/sfg_pkg.sv
// Shared widths for the bit-clock / frame-sync generator.
package sfg_pkg;
    parameter int SFG_DIV_W  = 8;   // divide value field width
    parameter int SFG_PER_W  = 12;  // frame period / sync width field width
    parameter int SFG_SYNC_N = 2;   // synchroniser stages on the external pin
endpackage

// File: rtl/sfg_src_sel.sv
// Source selector: produces one tick per source event. The internal source
// ticks on every clock; the external pin is synchronised and ticks once per
// rising edge. Assumes the external clock is slower than clk/2.
module sfg_src_sel #(
    parameter int SYNC_N = sfg_pkg::SFG_SYNC_N
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk_i,
    input  logic src_ext_i,
    output logic tick_o
);
    localparam int CHAIN_W = SYNC_N + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Shift the external pin through the synchroniser plus one edge stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], ext_clk_i};
    end

    logic ext_rise;
    assign ext_rise = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];

    // Pick the event source for the divider.
    always_comb begin
        tick_o = src_ext_i ? ext_rise : 1'b1;
    end

    // R2: an external tick never repeats on back-to-back cycles.
    a_r2_ext_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ext_i && tick_o) |=> !(src_ext_i && tick_o));
endmodule

// File: rtl/sfg_clk_div.sv
// Bit-clock divider: toggles the bit-clock phase every (div_val+1) source
// ticks while enabled; held at phase 0 while disabled. Reports a bit tick
// in the cycle before the phase goes from 0 to 1.
module sfg_clk_div #(
    parameter int DIV_W = sfg_pkg::SFG_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             src_tick_i,
    input  logic [DIV_W-1:0] div_val_i,
    output logic             phase_o,
    output logic             bit_tick_o
);
    logic [DIV_W-1:0] dcnt_q;
    logic             phase_q;
    logic             term;

    assign term = src_tick_i && (dcnt_q == div_val_i);

    // Count source ticks and flip the phase at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            dcnt_q  <= '0;
            phase_q <= 1'b0;
        end else if (src_tick_i) begin
            if (dcnt_q >= div_val_i) begin
                dcnt_q  <= '0;
                phase_q <= ~phase_q;
            end else begin
                dcnt_q <= dcnt_q + 1'b1;
            end
        end
    end

    assign phase_o    = phase_q;
    assign bit_tick_o = en_i && term && !phase_q;

    // R5: a cleared enable idles the phase on the next edge.
    a_r5_div_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !phase_o);
    // R1: the phase only moves on a terminal-count tick.
    a_r1_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !term) |=> $stable(phase_o));
endmodule

// File: rtl/sfg_framer.sv
// Frame counter: counts bit ticks to form frames of (per+1) bit clocks with
// the sync active for the first (wid+1) of them. Periodic or single frame.
// Runs only while run_i (both enables) is high; otherwise cleared.
module sfg_framer #(
    parameter int PER_W = sfg_pkg::SFG_PER_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             bit_tick_i,
    input  logic             per_mode_i,
    input  logic [PER_W-1:0] per_val_i,
    input  logic [PER_W-1:0] wid_val_i,
    output logic             fs_act_o,
    output logic             start_o
);
    logic [PER_W-1:0] cnt_q;
    logic             act_q;
    logic             done_q;
    logic             strb_q;

    // Advance the frame position on each bit tick; start or wrap frames.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q  <= '0;
            act_q  <= 1'b0;
            done_q <= 1'b0;
            strb_q <= 1'b0;
        end else begin
            strb_q <= 1'b0;
            if (bit_tick_i) begin
                if (!act_q) begin
                    if (!done_q) begin
                        act_q  <= 1'b1;
                        cnt_q  <= '0;
                        strb_q <= 1'b1;
                    end
                end else if (cnt_q >= per_val_i) begin
                    if (per_mode_i) begin
                        cnt_q  <= '0;
                        strb_q <= 1'b1;
                    end else begin
                        act_q  <= 1'b0;
                        done_q <= 1'b1;
                        cnt_q  <= '0;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign fs_act_o = act_q && (cnt_q <= wid_val_i);
    assign start_o  = strb_q;

    // R4: without both enables the sync is inactive next cycle.
    a_r4_gate_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !fs_act_o);
    // R8: the strobe lasts one cycle.
    a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    // R8: the strobe coincides with an active sync.
    a_r8_strobe_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> fs_act_o);
endmodule

// File: rtl/sclk_fsync_gen.sv
// Top of the bit-clock / frame-sync generator: source select, divider and
// frame counter, with output polarity applied last. Assumes configuration
// is changed only while the enables are low.
module sclk_fsync_gen (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_clk_i,
    input  logic        div_en_i,
    input  logic        fs_en_i,
    input  logic        src_ext_i,
    input  logic        fs_per_mode_i,
    input  logic        clk_pol_i,
    input  logic        fs_pol_i,
    input  logic [7:0]  div_val_i,
    input  logic [11:0] per_val_i,
    input  logic [11:0] wid_val_i,
    output logic        bclk_o,
    output logic        fsync_o,
    output logic        fstart_o
);
    logic src_tick, phase, bit_tick, fs_act, run;

    assign run = div_en_i && fs_en_i;

    sfg_src_sel u_src (
        .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk_i),
        .src_ext_i(src_ext_i), .tick_o(src_tick));

    sfg_clk_div #(.DIV_W(8)) u_div (
        .clk(clk), .rst_n(rst_n), .en_i(div_en_i), .src_tick_i(src_tick),
        .div_val_i(div_val_i), .phase_o(phase), .bit_tick_o(bit_tick));

    sfg_framer #(.PER_W(12)) u_frm (
        .clk(clk), .rst_n(rst_n), .run_i(run), .bit_tick_i(bit_tick),
        .per_mode_i(fs_per_mode_i), .per_val_i(per_val_i),
        .wid_val_i(wid_val_i), .fs_act_o(fs_act), .start_o(fstart_o));

    // Apply the selected polarities to the pins.
    always_comb begin
        bclk_o  = phase ^ clk_pol_i;
        fsync_o = fs_act ^ fs_pol_i;
    end

    // R4: a strobe needs both enables one cycle earlier.
    a_r4_strobe_gated: assert property (@(posedge clk) disable iff (!rst_n)
        fstart_o |-> $past(div_en_i && fs_en_i));
endmodule

// File: tb/sclk_fsync_gen_test.sv
module sclk_fsync_gen_test;
    logic clk = 0, rst_n = 0, ext_clk = 0;
    logic div_en = 0, fs_en = 0, src_ext = 0, per_mode = 1, cpol = 0, fpol = 0;
    logic [7:0] div_val = 0;
    logic [11:0] per_val = 0, wid_val = 0;
    logic bclk, fsync, fstart;

    int checks = 0, failures = 0;

    always #10 clk = ~clk;     // 50 MHz
    always #80 ext_clk = ~ext_clk;

    sclk_fsync_gen uut (
        .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .div_en_i(div_en),
        .fs_en_i(fs_en), .src_ext_i(src_ext), .fs_per_mode_i(per_mode),
        .clk_pol_i(cpol), .fs_pol_i(fpol), .div_val_i(div_val),
        .per_val_i(per_val), .wid_val_i(wid_val),
        .bclk_o(bclk), .fsync_o(fsync), .fstart_o(fstart));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard: expected frames {bits, active sync bits}.
    typedef struct { int bits; int fsn; string req; } frame_t;
    frame_t exp_q[$];
    int popped = 0;
    logic mon_on = 0;
    logic ph_prev = 0, started = 0;
    int bits = 0, fsn = 0;

    // Monitor: measure each frame between strobes and compare.
    always @(negedge clk) begin
        logic ph, fa, rise;
        ph = bclk ^ cpol;
        fa = fsync ^ fpol;
        rise = ph && !ph_prev;
        if (!mon_on) begin
            started = 0;
        end else begin
            if (fstart && !rise) chk(0, "R8 strobe off bit edge", 1, 0);
            if (rise) begin
                if (fstart) begin
                    chk(fa, "R8 sync at strobe", fa, 1);
                    if (started) begin
                        if (exp_q.size() == 0) chk(0, "R3 unexpected frame", bits, 0);
                        else begin
                            frame_t e;
                            e = exp_q.pop_front();
                            chk(bits == e.bits, {e.req, " frame bits"}, bits, e.bits);
                            chk(fsn == e.fsn, {e.req, " sync bits"}, fsn, e.fsn);
                            popped++;
                        end
                    end
                    started = 1;
                    bits = 0;
                    fsn = 0;
                end
                if (started) begin
                    bits++;
                    if (fa) fsn++;
                end
            end
        end
        ph_prev = ph;
    end

    // Driver: configure, push expected frames, run until they are scored.
    task automatic run_frames(input int d, input int p, input int w, input int n,
                              input string req);
        int target, guard;
        div_en = 0; fs_en = 0; mon_on = 0;
        repeat (2) @(posedge clk);
        div_val = 8'(d); per_val = 12'(p); wid_val = 12'(w); per_mode = 1;
        for (int i = 0; i < n; i++) begin
            frame_t e;
            e.bits = p + 1; e.fsn = ((w < p) ? w : p) + 1; e.req = req;
            exp_q.push_back(e);
        end
        target = popped + n;
        @(negedge clk);
        mon_on = 1; div_en = 1; fs_en = 1;
        guard = 0;
        while (popped < target && guard < 60000) begin
            @(negedge clk);
            guard++;
        end
        chk(popped == target, {req, " frames scored"}, popped, target);
        exp_q.delete();
        mon_on = 0;
        div_en = 0; fs_en = 0;
    endtask

    // Measure consecutive phase half-periods in clk cycles.
    task automatic half_period(input int expc, input string req);
        logic last;
        int cnt, guard;
        @(negedge clk);
        last = bclk; guard = 0;
        while (bclk == last && guard < 2000) begin @(negedge clk); guard++; end
        for (int k = 0; k < 3; k++) begin
            last = bclk; cnt = 0;
            while (bclk == last && cnt < 2000) begin @(negedge clk); cnt++; end
            chk(cnt == expc, req, cnt, expc);
        end
    endtask

    initial begin
        #(20 * 200000);
        chk(0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int nstrb, nfs, nchg;
        logic last;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(bclk == 0, "R9 reset bclk", bclk, 0);
        chk(fsync == 0, "R9 reset fsync", fsync, 0);
        chk(fstart == 0, "R9 reset fstart", fstart, 0);
        rst_n = 1;

        // R1: internal divide 0 and 3
        div_val = 0; div_en = 1;
        half_period(1, "R1 div0 half period");
        div_en = 0; @(negedge clk); div_val = 3; div_en = 1;
        half_period(4, "R1 div3 half period");
        div_en = 0; @(negedge clk);

        // R2: external pin, 8-cycle period, divide 1 -> 16 cycles per half
        src_ext = 1; div_val = 1; div_en = 1;
        half_period(16, "R2 ext half period");
        div_en = 0; src_ext = 0; @(negedge clk);

        // R4: divider alone runs bclk but no sync/strobe
        div_val = 0; per_val = 3; wid_val = 0; div_en = 1; fs_en = 0;
        nstrb = 0; nfs = 0; nchg = 0; last = bclk;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (fstart) nstrb++;
            if (fsync) nfs++;
            if (bclk != last) nchg++;
            last = bclk;
        end
        chk(nstrb == 0 && nfs == 0, "R4 no sync without fs_en", nstrb + nfs, 0);
        chk(nchg > 0, "R4 bclk runs with div_en alone", nchg, 1);
        div_en = 0;

        // R3: frame shapes
        run_frames(0, 7, 0, 3, "R3 p8w1");
        run_frames(1, 31, 15, 2, "R3 symmetric");
        run_frames(0, 32, 15, 2, "R3 p33");
        run_frames(0, 4095, 0, 1, "R3 p4096");

        // R5: disable mid-run, check idle, restart gives full frames
        div_val = 0; per_val = 9; wid_val = 4; div_en = 1; fs_en = 1;
        repeat (37) @(negedge clk);
        div_en = 0;
        @(negedge clk);
        chk(bclk == cpol, "R5 bclk idle after disable", bclk, cpol);
        chk(fsync == fpol, "R5 fsync inactive after disable", fsync, fpol);
        nchg = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (bclk != cpol || fsync != fpol || fstart) nchg++;
        end
        chk(nchg == 0, "R5 stays idle", nchg, 0);
        fs_en = 0;
        run_frames(0, 9, 4, 2, "R5 restart full frames");

        // R6: inverted polarities
        cpol = 1; fpol = 1;
        repeat (2) @(negedge clk);
        chk(bclk == 1, "R6 bclk idles high", bclk, 1);
        chk(fsync == 1, "R6 fsync idles high", fsync, 1);
        run_frames(2, 5, 2, 2, "R6 inverted frames");
        cpol = 0; fpol = 0;

        // R7: single frame mode, width 3 of 8
        @(negedge clk);
        per_mode = 0; div_val = 0; per_val = 7; wid_val = 2;
        div_en = 1; fs_en = 1;
        nstrb = 0; nfs = 0; last = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (fstart) nstrb++;
            if (bclk && !last && fsync) nfs++;
            last = bclk;
        end
        chk(nstrb == 1, "R7 one strobe", nstrb, 1);
        chk(nfs == 3, "R7 sync bits", nfs, 3);
        chk(fsync == 0, "R7 sync stays inactive", fsync, 0);
        div_en = 0; fs_en = 0; per_mode = 1;

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule